// File: doc/BRIEF.md
# Double-Buffered OUT Endpoint Buffer

This block is the receive store for one device-side OUT endpoint. It has two packet slots used in ping-pong order. When the host side presents an OUT token, the block answers at once with an accept or a NAK. Accepted packet bytes arrive one per strobe, followed by an end-of-packet strobe or a bad-packet strobe. Each completed packet raises a sticky interrupt bit. The processor then reads the packet one byte per strobe from a 32-bit read-only data register, with the byte in the low eight bits.

Filling and draining run independently. The host may fill one slot while the processor empties the other. Once both slots hold unread packets, every new token is refused until the processor has read the last byte of the older packet and that slot is free again. Packets longer than a slot are cut to the slot size, and this raises a separate sticky truncation flag.

Top module: `oep_pingpong`

## Requirements
- R1: After reset, reg_rdata is 0x00000000, pkt_irq and trunc_flag are 0, host_ack and host_nak are 0, and both slots are empty.
- R2: Each host_tok pulse given while no packet is being received gets exactly one one-cycle reply on the next cycle: host_ack if the slot next in ping-pong order is empty, otherwise host_nak.
- R3: While both slots hold unread packets, every token is answered with host_nak, even while the older packet is partly read. The first token after its last byte is read gets host_ack.
- R4: Each reg_rd strobe on a non-empty buffer returns, on the next cycle, the next byte of the oldest packet in reg_rdata[7:0], with reg_rdata[31:8] equal to zero.
- R5: Packets are read in arrival order. After the last byte of one packet is read, the next read returns the first byte of the following packet.
- R6: An end-of-packet strobe that completes an accepted, unflagged packet sets pkt_irq on the next cycle. pkt_irq stays set until irq_w1c is pulsed, and a completion in the same cycle as the clear wins.
- R7: A bad-packet strobe during reception discards the packet. pkt_irq is not set, the slot stays empty, and the next accepted packet uses that same slot.
- R8: Each slot holds SLOT_BYTES bytes (default 128, so 256 bytes in total). Bytes past that count are dropped, the packet reads back as its first SLOT_BYTES bytes, and trunc_flag is set until trunc_w1c is pulsed.
- R9: A reg_rd strobe while both slots are empty returns 0x00000000 and moves no read pointer, so the next packet still reads from its first byte.
- R10: A packet completed with zero data bytes sets pkt_irq but stores nothing and leaves both slots empty.
- R11: Bytes and end-of-packet strobes that follow a refused token are ignored: pkt_irq is not set and buffered data is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_tok | input | 1 | OUT token for this endpoint, one-cycle pulse |
| host_ack | output | 1 | Token accepted, one-cycle pulse |
| host_nak | output | 1 | Token refused, one-cycle pulse |
| pkt_valid | input | 1 | pkt_byte carries a data byte |
| pkt_byte | input | 8 | Received data byte |
| pkt_eop | input | 1 | End of the current packet |
| pkt_bad | input | 1 | Current packet is corrupt, discard it |
| reg_rd | input | 1 | Processor read strobe for the data register |
| reg_rdata | output | 32 | Data register, byte in bits 7:0 |
| pkt_irq | output | 1 | Sticky packet-complete interrupt |
| irq_w1c | input | 1 | Clears pkt_irq |
| trunc_flag | output | 1 | Sticky over-length packet flag |
| trunc_w1c | input | 1 | Clears trunc_flag |

## Verification
Every result lands one clock edge after its stimulus. The token reply, the interrupt and truncation flags after an end-of-packet, and the read data after a read strobe all update at the next rising edge. The bench drives each stimulus on a falling edge and checks the outputs on the following falling edge, half a period after the edge that updated them. Expected bytes come from a closed-form function of packet seed and index, and a bench model of the two slots tracks which one should answer. A sweep of packet lengths from zero to past the slot size runs on an 8-byte slot configuration.

// File: rtl/oep_pkg.sv
package oep_pkg;
   localparam int REG_W = 32;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      RPL_NONE = 2'd0,
      RPL_ACK  = 2'd1,
      RPL_NAK  = 2'd2
   } reply_t;
endpackage

// File: rtl/oep_store.sv
module oep_store #(
   parameter int SLOT_BYTES = 128,
   localparam int IDX_W = $clog2(SLOT_BYTES),
   localparam int ADDR_W = IDX_W + 1
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [oep_pkg::BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [oep_pkg::BYTE_W-1:0] rd_data
);
   localparam int DEPTH = 2 * SLOT_BYTES;

   logic [oep_pkg::BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/oep_fill.sv
module oep_fill #(
   parameter int SLOT_BYTES = 128,
   localparam int IDX_W = $clog2(SLOT_BYTES),
   localparam int ADDR_W = IDX_W + 1,
   localparam int CNT_W = $clog2(SLOT_BYTES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_tok,
   input  logic [1:0]                 slot_free,
   input  logic                       pkt_valid,
   input  logic [oep_pkg::BYTE_W-1:0] pkt_byte,
   input  logic                       pkt_eop,
   input  logic                       pkt_bad,
   output logic                       host_ack,
   output logic                       host_nak,
   output logic                       wr_en,
   output logic [ADDR_W-1:0]          wr_addr,
   output logic [oep_pkg::BYTE_W-1:0] wr_data,
   output logic                       done,
   output logic                       done_slot,
   output logic [CNT_W-1:0]           done_len,
   output logic                       done_trunc
);
   import oep_pkg::*;

   localparam logic [CNT_W-1:0] CAP = CNT_W'(SLOT_BYTES);

   reply_t           reply_q;
   logic             busy_q;
   logic             wr_sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             trunc_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             trunc_nx;
   logic             good_byte;

   assign good_byte = busy_q && pkt_valid && !pkt_bad;
   assign wr_en     = good_byte && (cnt_q != CAP);
   assign wr_addr   = {wr_sel_q, cnt_q[IDX_W-1:0]};
   assign wr_data   = pkt_byte;
   assign cnt_nx    = cnt_q + CNT_W'(wr_en);
   assign trunc_nx  = trunc_q || (good_byte && (cnt_q == CAP));

   assign done       = busy_q && pkt_eop && !pkt_bad;
   assign done_slot  = wr_sel_q;
   assign done_len   = cnt_nx;
   assign done_trunc = trunc_nx;

   assign host_ack = (reply_q == RPL_ACK);
   assign host_nak = (reply_q == RPL_NAK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reply_q  <= RPL_NONE;
         busy_q   <= 1'b0;
         wr_sel_q <= 1'b0;
         cnt_q    <= '0;
         trunc_q  <= 1'b0;
      end else begin
         reply_q <= RPL_NONE;
         if (host_tok && !busy_q) begin
            if (slot_free[wr_sel_q]) begin
               reply_q <= RPL_ACK;
               busy_q  <= 1'b1;
               cnt_q   <= '0;
               trunc_q <= 1'b0;
            end else begin
               reply_q <= RPL_NAK;
            end
         end else if (busy_q) begin
            if (pkt_bad) begin
               busy_q <= 1'b0;
            end else if (pkt_eop) begin
               busy_q <= 1'b0;
               if (cnt_nx != '0) wr_sel_q <= ~wr_sel_q;
            end else begin
               cnt_q   <= cnt_nx;
               trunc_q <= trunc_nx;
            end
         end
      end
   end

   // R2: one reply per token taken between packets
   a_r2_one_reply : assert property (@(posedge clk) disable iff (!rst_n)
      (host_tok && !busy_q) |=> (host_ack != host_nak));

   // R7: a bad packet ends reception without a completion
   a_r7_bad_drops : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && pkt_bad) |=> (!busy_q && $stable(wr_sel_q)));

   // R8: a completed length never exceeds the slot size
   a_r8_len_cap : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_len <= CAP));
endmodule

// File: rtl/oep_drain.sv
module oep_drain #(
   parameter int SLOT_BYTES = 128,
   localparam int IDX_W = $clog2(SLOT_BYTES),
   localparam int ADDR_W = IDX_W + 1,
   localparam int CNT_W = $clog2(SLOT_BYTES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_rd,
   input  logic [1:0]                 slot_valid,
   input  logic [1:0][CNT_W-1:0]      slot_len,
   output logic [ADDR_W-1:0]          rd_addr,
   input  logic [oep_pkg::BYTE_W-1:0] mem_byte,
   output logic [oep_pkg::REG_W-1:0]  reg_rdata,
   output logic                       done,
   output logic                       done_slot
);
   import oep_pkg::*;

   logic             rd_sel_q;
   logic [CNT_W-1:0] rd_idx_q;
   logic             hit;
   logic             last;

   assign hit       = reg_rd && slot_valid[rd_sel_q];
   assign last      = ((rd_idx_q + CNT_W'(1)) == slot_len[rd_sel_q]);
   assign done      = hit && last;
   assign done_slot = rd_sel_q;
   assign rd_addr   = {rd_sel_q, rd_idx_q[IDX_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_sel_q  <= 1'b0;
         rd_idx_q  <= '0;
         reg_rdata <= '0;
      end else if (reg_rd) begin
         reg_rdata <= hit ? REG_W'(mem_byte) : '0;
         if (hit) begin
            if (last) begin
               rd_idx_q <= '0;
               rd_sel_q <= ~rd_sel_q;
            end else begin
               rd_idx_q <= rd_idx_q + CNT_W'(1);
            end
         end
      end
   end

   // R9: empty reads return zero and leave the pointers alone
   a_r9_empty_read : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !slot_valid[rd_sel_q]) |=>
         ((reg_rdata == '0) && $stable(rd_sel_q) && $stable(rd_idx_q)));

   // R4: a read from a filled slot never runs past its stored length
   a_r4_idx_in_len : assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[rd_sel_q] |-> (rd_idx_q < slot_len[rd_sel_q]));
endmodule

// File: rtl/oep_pingpong.sv
module oep_pingpong #(
   parameter int SLOT_BYTES = 128
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_tok,
   output logic        host_ack,
   output logic        host_nak,
   input  logic        pkt_valid,
   input  logic [7:0]  pkt_byte,
   input  logic        pkt_eop,
   input  logic        pkt_bad,
   input  logic        reg_rd,
   output logic [31:0] reg_rdata,
   output logic        pkt_irq,
   input  logic        irq_w1c,
   output logic        trunc_flag,
   input  logic        trunc_w1c
);
   import oep_pkg::*;

   localparam int IDX_W = $clog2(SLOT_BYTES);
   localparam int ADDR_W = IDX_W + 1;
   localparam int CNT_W = $clog2(SLOT_BYTES + 1);
   localparam int NSLOT = 2;

   initial begin
      a_cfg_slot_pow2 : assert (SLOT_BYTES >= 2 && (SLOT_BYTES & (SLOT_BYTES - 1)) == 0)
         else $error("SLOT_BYTES must be a power of two of at least 2");
      a_cfg_reg_w : assert (REG_W == 32 && BYTE_W == 8)
         else $error("register and byte widths must match the port list");
   end

   logic [NSLOT-1:0]            slot_valid;
   logic [NSLOT-1:0][CNT_W-1:0] slot_len;

   logic                 wr_en;
   logic [ADDR_W-1:0]    wr_addr;
   logic [BYTE_W-1:0]    wr_data;
   logic [ADDR_W-1:0]    rd_addr;
   logic [BYTE_W-1:0]    mem_byte;
   logic                 fill_done;
   logic                 fill_slot;
   logic [CNT_W-1:0]     fill_len;
   logic                 fill_trunc;
   logic                 drain_done;
   logic                 drain_slot;

   oep_fill #(.SLOT_BYTES(SLOT_BYTES)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_tok   (host_tok),
      .slot_free  (~slot_valid),
      .pkt_valid  (pkt_valid),
      .pkt_byte   (pkt_byte),
      .pkt_eop    (pkt_eop),
      .pkt_bad    (pkt_bad),
      .host_ack   (host_ack),
      .host_nak   (host_nak),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .done       (fill_done),
      .done_slot  (fill_slot),
      .done_len   (fill_len),
      .done_trunc (fill_trunc)
   );

   oep_store #(.SLOT_BYTES(SLOT_BYTES)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (mem_byte)
   );

   oep_drain #(.SLOT_BYTES(SLOT_BYTES)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_rd     (reg_rd),
      .slot_valid (slot_valid),
      .slot_len   (slot_len),
      .rd_addr    (rd_addr),
      .mem_byte   (mem_byte),
      .reg_rdata  (reg_rdata),
      .done       (drain_done),
      .done_slot  (drain_slot)
   );

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic             v_q;
      logic [CNT_W-1:0] len_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q   <= 1'b0;
            len_q <= '0;
         end else if (fill_done && (fill_slot == 1'(g)) && (fill_len != '0)) begin
            v_q   <= 1'b1;
            len_q <= fill_len;
         end else if (drain_done && (drain_slot == 1'(g))) begin
            v_q   <= 1'b0;
         end
      end

      assign slot_valid[g] = v_q;
      assign slot_len[g]   = len_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_irq    <= 1'b0;
         trunc_flag <= 1'b0;
      end else begin
         if (fill_done)    pkt_irq <= 1'b1;
         else if (irq_w1c) pkt_irq <= 1'b0;
         if (fill_done && fill_trunc) trunc_flag <= 1'b1;
         else if (trunc_w1c)          trunc_flag <= 1'b0;
      end
   end

   // R3: with both slots holding packets no token is accepted
   a_r3_nak_when_full : assert property (@(posedge clk) disable iff (!rst_n)
      (host_tok && (&slot_valid)) |=> !host_ack);

   // R6: every completion raises the interrupt
   a_r6_irq_on_done : assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> pkt_irq);

   // R5: a slot is never both filled and drained in one cycle
   a_r5_no_slot_clash : assert property (@(posedge clk) disable iff (!rst_n)
      (fill_done && drain_done) |-> (fill_slot != drain_slot));
endmodule

// File: tb/oep_pingpong_bench.sv
module oep_pingpong_bench;
   localparam int SB = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_tok = 1'b0;
   logic        host_ack;
   logic        host_nak;
   logic        pkt_valid = 1'b0;
   logic [7:0]  pkt_byte = '0;
   logic        pkt_eop = 1'b0;
   logic        pkt_bad = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        pkt_irq;
   logic        irq_w1c = 1'b0;
   logic        trunc_flag;
   logic        trunc_w1c = 1'b0;

   int n_checks = 0;
   int n_fail = 0;

   // bench model of the two slots
   bit ev [2];
   int elen [2];
   int eseed [2];
   int ws = 0;
   int rs = 0;
   int rpos = 0;
   bit e_irq = 0;
   bit e_trunc = 0;

   always #5 clk = ~clk;

   oep_pingpong #(.SLOT_BYTES(SB)) u_oep_pingpong (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_tok   (host_tok),
      .host_ack   (host_ack),
      .host_nak   (host_nak),
      .pkt_valid  (pkt_valid),
      .pkt_byte   (pkt_byte),
      .pkt_eop    (pkt_eop),
      .pkt_bad    (pkt_bad),
      .reg_rd     (reg_rd),
      .reg_rdata  (reg_rdata),
      .pkt_irq    (pkt_irq),
      .irq_w1c    (irq_w1c),
      .trunc_flag (trunc_flag),
      .trunc_w1c  (trunc_w1c)
   );

   function automatic logic [7:0] bval(int seed, int i);
      return 8'((seed * 37 + i * 11 + 1) & 255);
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // token, bytes, then end-of-packet or bad strobe; checks reply and flags
   task automatic send_pkt(int len, int seed, bit bad, string tag);
      bit acc;
      acc = !ev[ws];
      @(negedge clk) host_tok = 1'b1;
      @(negedge clk) host_tok = 1'b0;
      check(host_ack == acc && host_nak == !acc, {tag, " R2 reply"},
            {host_ack, host_nak}, {acc, !acc});
      for (int i = 0; i < len; i++) begin
         pkt_valid = 1'b1;
         pkt_byte  = bval(seed, i);
         @(negedge clk);
      end
      pkt_valid = 1'b0;
      if (bad) pkt_bad = 1'b1;
      else     pkt_eop = 1'b1;
      @(negedge clk);
      pkt_bad = 1'b0;
      pkt_eop = 1'b0;
      if (acc && !bad) begin
         e_irq = 1'b1;
         if (len > SB) e_trunc = 1'b1;
         if (len > 0) begin
            ev[ws]    = 1'b1;
            elen[ws]  = (len > SB) ? SB : len;
            eseed[ws] = seed;
            ws ^= 1;
         end
      end
      check(pkt_irq == e_irq, {tag, " R6 irq"}, pkt_irq, e_irq);
      check(trunc_flag == e_trunc, {tag, " R8 trunc"}, trunc_flag, e_trunc);
   endtask

   task automatic read_one(string tag);
      logic [31:0] exp;
      exp = ev[rs] ? {24'h0, bval(eseed[rs], rpos)} : 32'h0;
      @(negedge clk) reg_rd = 1'b1;
      @(negedge clk) reg_rd = 1'b0;
      check(reg_rdata == exp, tag, reg_rdata, exp);
      if (ev[rs]) begin
         rpos++;
         if (rpos == elen[rs]) begin
            ev[rs] = 1'b0;
            rpos = 0;
            rs ^= 1;
         end
      end
   endtask

   task automatic drain_head(string tag);
      int n;
      n = elen[rs] - rpos;
      for (int i = 0; i < n; i++) read_one(tag);
   endtask

   task automatic clear_flags();
      @(negedge clk) begin irq_w1c = 1'b1; trunc_w1c = 1'b1; end
      @(negedge clk) begin irq_w1c = 1'b0; trunc_w1c = 1'b0; end
      e_irq = 1'b0;
      e_trunc = 1'b0;
      check(pkt_irq == 1'b0 && trunc_flag == 1'b0, "R6 R8 w1c clear",
            {pkt_irq, trunc_flag}, 0);
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      ev[0] = 0; ev[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 0);
      check(!pkt_irq && !trunc_flag, "R1 flags", {pkt_irq, trunc_flag}, 0);
      check(!host_ack && !host_nak, "R1 reply", {host_ack, host_nak}, 0);

      // R4 R5 R8 R10: length sweep across both slots
      for (int len = 0; len <= SB + 2; len++) begin
         send_pkt(len, len + 1, 1'b0, "sweep");
         if (len == 0) read_one("R10 zero-length read");
         else drain_head("R4 R8 sweep data");
         read_one("R9 empty after drain");
         clear_flags();
      end

      // R3: both slots full, NAK holds during partial drain
      send_pkt(3, 20, 1'b0, "fillA");
      send_pkt(5, 21, 1'b0, "fillB");
      clear_flags();
      send_pkt(4, 22, 1'b0, "R3 R11 full nak");
      read_one("R4 partial A");
      send_pkt(4, 22, 1'b0, "R3 nak held");
      drain_head("R5 rest of A");
      send_pkt(4, 22, 1'b0, "R3 accept after free");
      drain_head("R5 B order");
      drain_head("R5 C order");
      read_one("R9 empty");
      clear_flags();

      // R7: bad packet dropped, slot reused
      send_pkt(6, 30, 1'b1, "R7 bad");
      read_one("R7 R9 nothing stored");
      send_pkt(2, 31, 1'b0, "R7 after bad");
      drain_head("R7 reuse data");
      clear_flags();

      // R9: repeated empty reads keep pointers
      read_one("R9 empty a");
      read_one("R9 empty b");
      send_pkt(SB, 40, 1'b0, "R8 exact fit");
      drain_head("R9 R8 full slot");
      clear_flags();

      // R6: completion at the same edge as a clear wins
      @(negedge clk) host_tok = 1'b1;
      @(negedge clk) host_tok = 1'b0;
      pkt_valid = 1'b1; pkt_byte = bval(50, 0);
      @(negedge clk);
      pkt_valid = 1'b0; pkt_eop = 1'b1; irq_w1c = 1'b1;
      @(negedge clk);
      pkt_eop = 1'b0; irq_w1c = 1'b0;
      check(pkt_irq == 1'b1, "R6 set beats clear", pkt_irq, 1);
      ev[ws] = 1'b1; elen[ws] = 1; eseed[ws] = 50; ws ^= 1;
      drain_head("R4 last packet");
      summary();
   end
endmodule